// File: doc/BRIEF.md
# LIN Transmit Collision Detector

This block sends bytes on a single-wire LIN bus. It serialises each byte into a ten-bit frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts sixteen sub-bit ticks. The ticks come from an external tick-enable pulse. Software places one byte in a holding register, and the block moves that byte into its frame shifter as soon as the shifter is free. This lets two frames go out back to back.

The bus level is fed back through a two-flop synchronizer. At one tick inside every bit, the block compares the level it is driving with the level that came back. A 2-bit mode input enables the check and picks the tick. If the two levels differ, another node has won the bus. The block then drops the frame and returns the line to idle. It also throws away any byte in the holding register, raises the empty and complete flags, and sets a sticky error flag. While that flag is set, the block stays locked. Optional inversion of the driven and the received level is supported. The two inversion controls must be set to the same value, or the check reports false collisions.

Top module: `lin_tx_collide`

## Requirements
- R1: After reset, the line is at the idle level (`tx_out` = 1 with no inversion), `tdre` = 1, `tc` = 1 and `berr` = 0.
- R2: A frame is a 0 start bit, then eight data bits with bit 0 first, then a 1 stop bit. Each bit lasts 16 cycles in which `tick_en` is high. The first bit starts the cycle after the byte is moved out of the holding register.
- R3: A write (`wr_valid` high) is accepted only when `tdre` = 1. `tdre` falls the cycle after an accepted write. It rises again when the byte moves into the shifter, which happens as soon as the shifter is idle.
- R4: `tc` rises when the stop bit ends and no byte is waiting. An accepted write clears it. While `tc` = 1, the line is idle.
- R5: `cfg_mode` selects the compare. 2'b01 compares at tick 9 of each bit, and 2'b10 compares at tick 13. 2'b00 and 2'b11 never compare. A bus disturbance that covers only ticks 12 to 15 of a bit therefore flags in mode 2'b10 but not in mode 2'b01.
- R6: No compare takes place while no frame is being sent. Pulling the bus while the line is idle never sets `berr`.
- R7: On a mismatch, the frame is aborted and the line is idle from the next cycle on. Any byte in the holding register is discarded and never sent, and `tdre` and `tc` are both 1.
- R8: A mismatch sets `berr`, which stays set until a cycle in which `clr_err` is high. While `berr` = 1, writes are ignored and no frame starts.
- R9: While `cfg_mode` is 2'b00 or 2'b11, `berr` is forced to 0 from the next cycle.
- R10: `cfg_tx_inv` inverts the driven level, so idle becomes 0. `cfg_rx_inv` inverts the received level before the compare. With both set, frames check cleanly. With only `cfg_tx_inv` set, the start bit flags an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One sub-bit tick (1/16 of a bit) |
| cfg_mode | input | 2 | Collision check mode and sample point |
| cfg_tx_inv | input | 1 | Invert driven line level |
| cfg_rx_inv | input | 1 | Invert received line level |
| wr_valid | input | 1 | Write a byte to the holding register |
| wr_data | input | 8 | Byte to send |
| clr_err | input | 1 | Clear the sticky collision flag |
| rx_in | input | 1 | Bus level read back, asynchronous |
| tx_out | output | 1 | Driven line level |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| berr | output | 1 | Sticky collision flag |

## Verification
Several properties are checked on every cycle: the empty and complete flags and the idle line in the cycle `berr` rises, the hold of `berr` until a clear, the forced clear of `berr` when the mode is off, the empty holding register during lockout, and the idle line whenever `tc` is set. Other behaviour is covered only by the bench scenarios. These are the frame bit order and the back-to-back frames, the exact tick at which each mode samples (shown by a disturbance placed between the two sample points), and the discarded byte that never appears later. The scenarios also show that a disturbance on an idle line goes unnoticed, and that mismatched inversion settings cause a false collision. A behavioural model in the bench follows every output on every clock, including a run with a slower tick rate.

// File: rtl/lin_txcd_pkg.sv
package lin_txcd_pkg;

    typedef enum logic [1:0] {
        CHK_OFF   = 2'b00,
        CHK_EARLY = 2'b01,
        CHK_LATE  = 2'b10,
        CHK_RSVD  = 2'b11
    } chk_mode_e;

    localparam int DEF_TICKS_PER_BIT = 16;
    localparam int DEF_EARLY_TICK    = 9;
    localparam int DEF_LATE_TICK     = 13;
    localparam int DEF_SYNC_STAGES   = 2;

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RESET_VAL}};
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lin_sample_sel.sv
module lin_sample_sel
    import lin_txcd_pkg::*;
#(
    parameter int TICK_W     = 4,
    parameter int EARLY_TICK = DEF_EARLY_TICK,
    parameter int LATE_TICK  = DEF_LATE_TICK
) (
    input  logic [1:0]        mode,
    output logic              chk_en,
    output logic [TICK_W-1:0] sample_tick
);
    always_comb begin
        chk_en      = 1'b0;
        sample_tick = TICK_W'(EARLY_TICK);
        case (chk_mode_e'(mode))
            CHK_EARLY: begin
                chk_en      = 1'b1;
                sample_tick = TICK_W'(EARLY_TICK);
            end
            CHK_LATE: begin
                chk_en      = 1'b1;
                sample_tick = TICK_W'(LATE_TICK);
            end
            default: begin
                chk_en      = 1'b0;
                sample_tick = TICK_W'(EARLY_TICK);
            end
        endcase
    end
endmodule

// File: rtl/lin_bit_cmp.sv
module lin_bit_cmp #(
    parameter int TICK_W = 4
) (
    input  logic              active,
    input  logic              tick_en,
    input  logic              chk_en,
    input  logic [TICK_W-1:0] tick,
    input  logic [TICK_W-1:0] sample_tick,
    input  logic              tx_bit,
    input  logic              rx_sync,
    input  logic              rx_inv,
    output logic              mismatch
);
    logic rx_bit;
    logic at_sample;

    assign rx_bit    = rx_sync ^ rx_inv;
    assign at_sample = active && tick_en && chk_en && (tick == sample_tick);
    assign mismatch  = at_sample && (rx_bit != tx_bit);
endmodule

// File: rtl/lin_tx_collide.sv
module lin_tx_collide
    import lin_txcd_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = DEF_TICKS_PER_BIT,
    parameter int SYNC_STAGES   = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_tx_inv,
    input  logic              cfg_rx_inv,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_err,
    input  logic              rx_in,
    output logic              tx_out,
    output logic              tdre,
    output logic              tc,
    output logic              berr
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int TICK_W  = $clog2(TICKS_PER_BIT);
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic [TICK_W-1:0]  tick;
        logic [BIT_W-1:0]   bitn;
        logic [FRAME_W-1:0] frame;
        logic               hold_full;
        logic [DATA_W-1:0]  hold_data;
        logic               tc;
        logic               berr;
    } st_t;

    localparam st_t RST_ST = '{
        busy:      1'b0,
        tick:      '0,
        bitn:      '0,
        frame:     '1,
        hold_full: 1'b0,
        hold_data: '0,
        tc:        1'b1,
        berr:      1'b0
    };

    st_t st_d, st_q;

    logic              rx_sync;
    logic              chk_en;
    logic [TICK_W-1:0] sample_tick;
    logic              mismatch;
    logic              tx_level;
    logic              wr_accept;
    logic              start;
    logic              frame_end;

    lin_rx_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_sync)
    );

    lin_sample_sel #(
        .TICK_W (TICK_W)
    ) u_sel (
        .mode        (cfg_mode),
        .chk_en      (chk_en),
        .sample_tick (sample_tick)
    );

    lin_bit_cmp #(
        .TICK_W (TICK_W)
    ) u_cmp (
        .active      (st_q.busy),
        .tick_en     (tick_en),
        .chk_en      (chk_en),
        .tick        (st_q.tick),
        .sample_tick (sample_tick),
        .tx_bit      (st_q.frame[0]),
        .rx_sync     (rx_sync),
        .rx_inv      (cfg_rx_inv),
        .mismatch    (mismatch)
    );

    always_comb begin
        st_d      = st_q;
        frame_end = 1'b0;
        wr_accept = wr_valid && !st_q.berr && !st_q.hold_full;
        start     = !st_q.busy && st_q.hold_full && !st_q.berr;

        // shifter: load from holding register or advance one tick
        if (start) begin
            st_d.busy      = 1'b1;
            st_d.tick      = '0;
            st_d.bitn      = '0;
            st_d.frame     = {1'b1, st_q.hold_data, 1'b0};
            st_d.hold_full = 1'b0;
        end else if (st_q.busy && tick_en) begin
            if (st_q.tick == LAST_TICK) begin
                st_d.tick = '0;
                if (st_q.bitn == LAST_BIT) begin
                    st_d.busy = 1'b0;
                    frame_end = 1'b1;
                end else begin
                    st_d.bitn  = st_q.bitn + 1'b1;
                    st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                end
            end else begin
                st_d.tick = st_q.tick + 1'b1;
            end
        end

        // holding register write
        if (wr_accept) begin
            st_d.hold_full = 1'b1;
            st_d.hold_data = wr_data;
            st_d.tc        = 1'b0;
        end

        if (frame_end) begin
            st_d.tc = !st_d.hold_full;
        end

        if (clr_err) begin
            st_d.berr = 1'b0;
        end

        // collision: abort, discard, flag, lock
        if (mismatch) begin
            st_d.busy      = 1'b0;
            st_d.hold_full = 1'b0;
            st_d.tc        = 1'b1;
            st_d.berr      = 1'b1;
            st_d.frame     = '1;
        end

        if (!chk_en) begin
            st_d.berr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_level = st_q.busy ? st_q.frame[0] : 1'b1;
    assign tx_out   = tx_level ^ cfg_tx_inv;
    assign tdre     = !st_q.hold_full;
    assign tc       = st_q.tc;
    assign berr     = st_q.berr;
endmodule

// File: rtl/lin_tx_collide_chk.sv
module lin_tx_collide_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       cfg_tx_inv,
    input logic       wr_valid,
    input logic       clr_err,
    input logic       tx_out,
    input logic       tdre,
    input logic       tc,
    input logic       berr
);
    logic mode_on;
    assign mode_on = (cfg_mode == 2'b01) || (cfg_mode == 2'b10);

    // R3: the holding register only fills after a write
    a_r3_fill_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tdre) |-> $past(wr_valid));

    // R4: complete implies an idle line
    a_r4_tc_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (tx_out == !cfg_tx_inv));

    // R7: abort effects visible when the flag rises
    a_r7_abort_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr) |-> (tdre && tc && (tx_out == !cfg_tx_inv)));

    // R8: sticky until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (berr && !clr_err && mode_on) |=> berr);

    // R8: nothing buffered while locked
    a_r8_locked_empty: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> (tdre && tc));

    // R9: disabled check clears the flag
    a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |=> !berr);
endmodule

bind lin_tx_collide lin_tx_collide_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_tx_inv (cfg_tx_inv),
    .wr_valid   (wr_valid),
    .clr_err    (clr_err),
    .tx_out     (tx_out),
    .tdre       (tdre),
    .tc         (tc),
    .berr       (berr)
);

// File: tb/tb_lin_tx_collide.sv
`timescale 1ns/1ps
module tb_lin_tx_collide;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [1:0] cfg_mode = 2'b01;
    logic       cfg_tx_inv = 1'b0;
    logic       cfg_rx_inv = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       clr_err = 1'b0;
    logic       pull_low = 1'b0;
    logic       rx_in;
    logic       tx_out, tdre, tc, berr;

    int errors = 0;
    int checks = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign rx_in = pull_low ? 1'b0 : tx_out;

    lin_tx_collide dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_mode(cfg_mode),
        .cfg_tx_inv(cfg_tx_inv), .cfg_rx_inv(cfg_rx_inv), .wr_valid(wr_valid),
        .wr_data(wr_data), .clr_err(clr_err), .rx_in(rx_in), .tx_out(tx_out),
        .tdre(tdre), .tc(tc), .berr(berr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // tick generator
    always @(negedge clk) begin
        tick_en = (tick_cnt == 0);
        tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
    end

    // behavioural reference model
    bit       m_busy, m_full, m_tc, m_berr, m_s1, m_s2;
    int       m_tick, m_bit;
    bit [9:0] m_frame;
    bit [7:0] m_hold;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_full = 0; m_tc = 1; m_berr = 0; m_s1 = 1; m_s2 = 1;
            m_tick = 0; m_bit = 0; m_frame = '1; m_hold = 0;
        end else begin
            bit on, hit, acc, fin;
            int sp;
            on  = (cfg_mode == 2'd1) || (cfg_mode == 2'd2);
            sp  = (cfg_mode == 2'd1) ? 9 : 13;
            hit = m_busy && tick_en && on && (m_tick == sp) && ((m_s2 ^ cfg_rx_inv) != m_frame[0]);
            acc = wr_valid && !m_berr && !m_full;
            fin = 0;
            if (!m_busy && m_full && !m_berr) begin
                m_busy = 1; m_tick = 0; m_bit = 0;
                m_frame = {1'b1, m_hold, 1'b0}; m_full = 0;
            end else if (m_busy && tick_en) begin
                if (m_tick == 15) begin
                    m_tick = 0;
                    if (m_bit == 9) begin m_busy = 0; fin = 1; end
                    else begin m_bit++; m_frame = {1'b1, m_frame[9:1]}; end
                end else m_tick++;
            end
            if (acc) begin m_full = 1; m_hold = wr_data; m_tc = 0; end
            if (fin) m_tc = !m_full;
            if (clr_err) m_berr = 0;
            if (hit) begin m_busy = 0; m_full = 0; m_tc = 1; m_berr = 1; m_frame = '1; end
            if (!on) m_berr = 0;
            m_s2 = m_s1;
            m_s1 = rx_in;
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2 tx_out", tx_out, int'((m_busy ? m_frame[0] : 1'b1) ^ cfg_tx_inv));
            chk("R3 tdre", tdre, int'(!m_full));
            chk("R4 tc", tc, int'(m_tc));
            chk("R8 berr", berr, int'(m_berr));
        end
    end

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic wait_start(input logic lvl);
        do @(negedge clk); while (tx_out != lvl);
    endtask

    task automatic capture(input logic inv, input logic [7:0] exp, input string tag);
        logic [7:0] got;
        wait_start(inv);
        repeat (8) @(negedge clk);
        chk({tag, " start"}, int'(tx_out ^ inv), 0);
        for (int i = 0; i < 8; i++) begin
            repeat (16) @(negedge clk);
            got[i] = tx_out ^ inv;
        end
        repeat (16) @(negedge clk);
        chk({tag, " stop"}, int'(tx_out ^ inv), 1);
        chk({tag, " data"}, int'(got), int'(exp));
    endtask

    task automatic wait_tc();
        while (tc == 1'b1) @(negedge clk);
        while (tc == 1'b0) @(negedge clk);
    endtask

    // sends 0x01 and pulls the bus in ticks 12..15 of data bit 0 (seen after sync)
    task automatic disturb_frame(input logic [7:0] second, input bit use_second);
        write_byte(8'h01);
        wait_start(1'b0);
        if (use_second) begin
            write_byte(second);
            #1 chk("R3 second byte buffered", tdre, 0);
            repeat (24) @(negedge clk);
        end else begin
            repeat (26) @(negedge clk);
        end
        pull_low = 1'b1;
        repeat (4) @(negedge clk);
        pull_low = 1'b0;
        #1;
    endtask

    initial begin
        int lows;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 tx idle", tx_out, 1);
        chk("R1 tdre", tdre, 1);
        chk("R1 tc", tc, 1);
        chk("R1 berr", berr, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 / R3 / R4: back-to-back frames, mode 01
        cfg_mode = 2'b01;
        write_byte(8'hA5);
        #1 chk("R3 tdre after write", tdre, 0);
        @(negedge clk); #1 chk("R3 tdre after move", tdre, 1);
        write_byte(8'h3C);
        fork
            capture(1'b0, 8'hA5, "R2 first");
        join
        capture(1'b0, 8'h3C, "R2 second");
        repeat (10) @(negedge clk);
        #1 chk("R4 tc after last frame", tc, 1);
        chk("R5 mode01 no flag", berr, 0);

        // R5: disturbance between sample points, mode 01 ignores it
        disturb_frame(8'h00, 0);
        wait_tc();
        #1 chk("R5 mode01 misses late disturbance", berr, 0);

        // R5 / R7 / R8: mode 10 catches it, buffered byte discarded
        cfg_mode = 2'b10;
        disturb_frame(8'hFF, 1);
        chk("R8 berr set", berr, 1);
        chk("R7 tdre set", tdre, 1);
        chk("R7 tc set", tc, 1);
        chk("R7 line idle", tx_out, 1);
        write_byte(8'h55);
        #1 chk("R8 write ignored", tdre, 1);
        lows = 0;
        repeat (100) begin @(negedge clk); if (tx_out == 1'b0) lows++; end
        chk("R8 no frame while locked", lows, 0);
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        #1 chk("R8 cleared", berr, 0);
        lows = 0;
        repeat (200) begin @(negedge clk); if (tx_out == 1'b0) lows++; end
        chk("R7 discarded byte never sent", lows, 0);

        // R6: disturbance on idle line
        cfg_mode = 2'b01;
        @(negedge clk); pull_low = 1'b1;
        repeat (10) @(negedge clk); pull_low = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R6 idle disturbance ignored", berr, 0);

        // R9: disabling clears the flag
        cfg_mode = 2'b10;
        disturb_frame(8'h00, 0);
        chk("R9 precondition flag", berr, 1);
        @(negedge clk); cfg_mode = 2'b00;
        @(negedge clk); #1 chk("R9 mode off clears", berr, 0);

        // R5: mode 11 never checks
        cfg_mode = 2'b11;
        disturb_frame(8'h00, 0);
        wait_tc();
        #1 chk("R5 mode11 no flag", berr, 0);

        // R10: matched inversion
        cfg_mode = 2'b01;
        @(negedge clk); cfg_tx_inv = 1'b1; cfg_rx_inv = 1'b1;
        repeat (4) @(negedge clk);
        #1 chk("R10 inverted idle", tx_out, 0);
        write_byte(8'h5A);
        capture(1'b1, 8'h5A, "R10 inverted");
        repeat (4) @(negedge clk);
        #1 chk("R10 matched no flag", berr, 0);

        // R10: mismatched inversion gives false error
        @(negedge clk); cfg_rx_inv = 1'b0;
        repeat (4) @(negedge clk);
        write_byte(8'h00);
        repeat (30) @(negedge clk);
        #1 chk("R10 mismatch flags", berr, 1);
        @(negedge clk); clr_err = 1'b1; cfg_tx_inv = 1'b0;
        @(negedge clk); clr_err = 1'b0;
        repeat (4) @(negedge clk);

        // R2: slow tick rate
        tick_div = 3;
        write_byte(8'h96);
        wait_tc();
        #1 chk("R2 slow frame no flag", berr, 0);
        chk("R4 slow frame complete", tc, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule